// File: doc/BRIEF.md
# Clock-Generator Two-Wire Control Register Slave

This block is the serial control port of a clock generator. It listens on a two-wire bus (serial clock plus open-drain data) and keeps a small bank of control bytes. The clock-control logic reads these bytes in parallel. The open-drain data pin is modelled as a sampled input plus a drive-low enable. Both bus lines are resynchronised into the system clock domain, and every bus event is decoded from edges of the synchronised copies. For this to work, the system clock must run at least ten times faster than the serial clock.

A write transfer carries the slave address and then two bytes that the block acknowledges but does not keep: a command byte and a byte count. After those, every data byte fills the next register, starting at register 0. A read transfer needs no command phase. The block streams register 0, then register 1, and so on, for as long as the master acknowledges. The bank holds defaults from power-up, one read-only identification byte, and a nibble that captures four frequency-select strap pins while reset is held. The clock-control logic uses register 4 bit 0 as the spread-spectrum enable and bit 1 as the spread-amplitude select.

Top module: `clkgen_i2c_regs`

## Requirements
- R1: The block acknowledges only the address bytes 0xD2 (write) and 0xD3 (read), which is the 7-bit address 1101001 followed by the direction bit. For any other address it gives no acknowledge and ignores all further bytes until the next start.
- R2: In a write, the two bytes after the address are acknowledged and not stored. Each later byte is acknowledged and written to register 0, 1, 2 and so on in turn, and the register output is updated while the serial clock is low.
- R3: In a read, the block sends register 0 first and then each next register after every master acknowledge, MSB first. It stops driving after a master not-acknowledge.
- R4: The acknowledge is a drive-low on data during the ninth clock of each accepted byte. The data drive changes only while the serial clock is low.
- R5: After reset the data line is released and the registers hold register 0 = 0x00, register 1 = 0x0F, register 2 = 0xFF, register 3 = 0x37, register 4 bits 3:0 = 0 and register 5 = 0x03.
- R6: Register 6 always reads 0x57, and writes to it have no effect.
- R7: Register 4 bits 7:4 hold the strap input as sampled during reset. Later strap changes and bus writes leave them unchanged. Bits 3:0 are writable.
- R8: Data bytes sent to indices 7 and above are acknowledged and then discarded. Reads from those indices return 0xFF.
- R9: A repeated start in the middle of a transfer restarts address reception. Writes made before it are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Sampled serial data line |
| sda_oe_o | output | 1 | Drive data line low when 1 |
| strap_fs_i | input | 4 | Frequency-select straps, captured during reset |
| regs_o | output | NUM_REGS*8 | Register bank, register i at bits 8i+7:8i |

## Verification
The bound checker watches several properties on every cycle. The data drive and the register outputs may change only while the serial clock is low. The identification byte and the captured strap nibble must never move after reset. The data line must be released during reset. The checker cannot judge bus meaning: whether an acknowledge came after the right byte, whether data went to the right index, the read ordering, the 0xFF returned past the bank, and the effect of a repeated start. Only the bench can show these, through directed and seeded random transfers that it compares against its own register model.

// File: rtl/clkgen_i2c_pkg.sv
// Shared definitions for the clock-generator serial register slave.
// Holds the transfer-phase encoding and the per-register reset and write masks.
package clkgen_i2c_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_WDATA,
        PH_RDATA
    } phase_t;

    localparam int STRAP_REG = 4;
    localparam int ID_REG    = 6;
    localparam logic [7:0] ID_VALUE = 8'h57;

    // Reset value of each register (strap nibble merged separately).
    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            1:       return 8'h0F;
            2:       return 8'hFF;
            3:       return 8'h37;
            5:       return 8'h03;
            ID_REG:  return ID_VALUE;
            default: return 8'h00;
        endcase
    endfunction

    // Bits of each register that bus writes may change.
    function automatic logic [7:0] reg_wmask(input int idx);
        case (idx)
            STRAP_REG: return 8'h0F;
            ID_REG:    return 8'h00;
            default:   return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/clkgen_i2c_sync.sv
// Bus line synchroniser and event decoder.
// Resamples both bus lines through STAGES flops and flags clock edges,
// start and stop. Assumes the system clock is >= 10x the serial clock.
module clkgen_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // Shift the raw lines in and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    // Decode bus events from the synchronised lines.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
        sda_bit   = sda_s;
    end

endmodule

// File: rtl/clkgen_i2c_engine.sv
// Byte-level protocol engine.
// Shifts bits, issues acknowledges, walks the address / command / count /
// data sequence and streams read data. Assumes events from clkgen_i2c_sync.
module clkgen_i2c_engine
    import clkgen_i2c_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h69,
    parameter int         PTR_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             sda_bit,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic             sda_oe
);

    localparam logic [PTR_W-1:0] PTR_MAX = '1;

    phase_t           phase_q;
    logic [3:0]       bit_cnt_q;
    logic [7:0]       shreg_q;
    logic             rw_q;
    logic             mack_q;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_inc;
    logic             rx_phase;

    assign rd_idx   = ptr_q;
    assign ptr_inc  = (ptr_q == PTR_MAX) ? ptr_q : ptr_q + 1'b1;
    assign rx_phase = (phase_q == PH_ADDR) || (phase_q == PH_CMD) ||
                      (phase_q == PH_CNT)  || (phase_q == PH_WDATA);

    // Protocol sequencer: reacts to one bus event per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            bit_cnt_q <= 4'd0;
            shreg_q   <= 8'h00;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            ptr_q     <= '0;
            sda_oe    <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= 8'h00;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                phase_q   <= PH_ADDR;
                bit_cnt_q <= 4'd0;
                ptr_q     <= '0;
                sda_oe    <= 1'b0;
            end else if (stop_det) begin
                phase_q   <= PH_IDLE;
                bit_cnt_q <= 4'd0;
                sda_oe    <= 1'b0;
            end else if (scl_rise) begin
                if (rx_phase && bit_cnt_q < 4'd8) begin
                    shreg_q   <= {shreg_q[6:0], sda_bit};
                    bit_cnt_q <= bit_cnt_q + 4'd1;
                end else if (phase_q == PH_RDATA) begin
                    if (bit_cnt_q < 4'd8) begin
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                    end else if (bit_cnt_q == 4'd8) begin
                        mack_q    <= ~sda_bit;
                        bit_cnt_q <= 4'd9;
                    end
                end
            end else if (scl_fall) begin
                if (phase_q == PH_RDATA) begin
                    if (bit_cnt_q < 4'd8) begin
                        shreg_q <= {shreg_q[6:0], 1'b1};
                        sda_oe  <= ~shreg_q[6];
                    end else if (bit_cnt_q == 4'd8) begin
                        sda_oe <= 1'b0;
                    end else if (mack_q) begin
                        shreg_q   <= rd_data;
                        sda_oe    <= ~rd_data[7];
                        ptr_q     <= ptr_inc;
                        bit_cnt_q <= 4'd0;
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end else if (rx_phase && bit_cnt_q == 4'd8) begin
                    bit_cnt_q <= 4'd9;
                    case (phase_q)
                        PH_ADDR: begin
                            if (shreg_q[7:1] == SLAVE_ADDR) begin
                                sda_oe <= 1'b1;
                                rw_q   <= shreg_q[0];
                            end else begin
                                phase_q <= PH_IDLE;
                            end
                        end
                        PH_WDATA: begin
                            sda_oe  <= 1'b1;
                            wr_en   <= 1'b1;
                            wr_idx  <= ptr_q;
                            wr_data <= shreg_q;
                            ptr_q   <= ptr_inc;
                        end
                        default: sda_oe <= 1'b1;
                    endcase
                end else if (rx_phase && bit_cnt_q == 4'd9) begin
                    sda_oe    <= 1'b0;
                    bit_cnt_q <= 4'd0;
                    case (phase_q)
                        PH_ADDR: begin
                            if (rw_q) begin
                                phase_q <= PH_RDATA;
                                shreg_q <= rd_data;
                                sda_oe  <= ~rd_data[7];
                                ptr_q   <= ptr_inc;
                            end else begin
                                phase_q <= PH_CMD;
                            end
                        end
                        PH_CMD:  phase_q <= PH_CNT;
                        PH_CNT:  phase_q <= PH_WDATA;
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/clkgen_i2c_regfile.sv
// Control register bank.
// Each register has its own reset value and write mask; the strap register
// captures the strap pins during reset. Indices past the bank read 0xFF.
module clkgen_i2c_regfile
    import clkgen_i2c_pkg::*;
#(
    parameter int NUM_REGS = 7,
    parameter int PTR_W    = 4,
    parameter int STRAP_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [STRAP_W-1:0]    strap_fs_i,
    input  logic                  wr_en,
    input  logic [PTR_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [PTR_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] regs_o
);

    logic [7:0] reg_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [7:0] DEF  = reg_default(i);
        localparam logic [7:0] MASK = reg_wmask(i);
        logic [7:0] rst_val;

        if (i == STRAP_REG) begin : g_strap
            assign rst_val = {strap_fs_i, DEF[7-STRAP_W:0]};
        end else begin : g_plain
            assign rst_val = DEF;
        end

        // Hold one register; masked bits follow bus writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_q[i] <= rst_val;
            end else if (wr_en && wr_idx == PTR_W'(i)) begin
                reg_q[i] <= (reg_q[i] & ~MASK) | (wr_data & MASK);
            end
        end

        assign regs_o[8*i +: 8] = reg_q[i];
    end

    // Read selection with 0xFF beyond the bank.
    always_comb begin
        rd_data = 8'hFF;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_idx == PTR_W'(k)) rd_data = reg_q[k];
        end
    end

endmodule

// File: rtl/clkgen_i2c_regs.sv
// Top of the clock-generator two-wire register slave.
// Joins synchroniser, protocol engine and register bank. Assumes clk runs
// at least 10x the serial clock and rst_n is synchronous, active low.
module clkgen_i2c_regs #(
    parameter int         NUM_REGS    = 7,
    parameter int         PTR_W       = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] SLAVE_ADDR  = 7'h69
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic [3:0]            strap_fs_i,
    output logic [NUM_REGS*8-1:0] regs_o
);

    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             sda_bit;
    logic [7:0]       rd_data;
    logic [PTR_W-1:0] rd_idx;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    clkgen_i2c_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit)
    );

    clkgen_i2c_engine #(.SLAVE_ADDR(SLAVE_ADDR), .PTR_W(PTR_W)) engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe_o)
    );

    clkgen_i2c_regfile #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .STRAP_W(4)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_fs_i (strap_fs_i),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .regs_o     (regs_o)
    );

endmodule

// File: rtl/clkgen_i2c_regs_chk.sv
// Assertion checker for clkgen_i2c_regs, attached by bind below.
// Assumes the serial clock stays low for several system clocks per bit.
module clkgen_i2c_regs_chk #(
    parameter int NUM_REGS = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe_o,
    input logic [NUM_REGS*8-1:0] regs_o
);

    localparam int ID_LSB    = 6 * 8;
    localparam int STRAP_MSB = 4 * 8 + 7;

    AST_DRIVE_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i); // R4

    AST_REG_UPDATE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_o) |-> !scl_i); // R2

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        regs_o[ID_LSB +: 8] == 8'h57); // R6

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(regs_o[STRAP_MSB -: 4])); // R7

    AST_RELEASE_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> !sda_oe_o); // R5

endmodule

bind clkgen_i2c_regs clkgen_i2c_regs_chk #(.NUM_REGS(NUM_REGS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .regs_o   (regs_o)
);

// File: tb/clkgen_i2c_regs_tb_top.sv
// Self-checking bench: bus master model plus a register scoreboard.
module clkgen_i2c_regs_tb_top;

    localparam int NREG = 7;
    localparam int Q    = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            m_scl = 1'b1;
    logic            m_sda = 1'b1;
    logic            sda_oe;
    logic            sda_line;
    logic [3:0]      strap = 4'hA;
    logic [NREG*8-1:0] regs;
    logic [7:0]      exp_r [NREG];
    int              total = 0;
    int              bad = 0;

    always #2 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    clkgen_i2c_regs dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .strap_fs_i (strap),
        .regs_o     (regs)
    );

    function automatic logic [7:0] wmask(input int idx);
        if (idx == 4) return 8'h0F;
        if (idx >= 6) return 8'h00;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] exp_read(input int idx);
        if (idx >= NREG) return 8'hFF;
        return exp_r[idx];
    endfunction

    task automatic model_write(input int idx, input logic [7:0] d);
        if (idx < NREG) exp_r[idx] = (exp_r[idx] & ~wmask(idx)) | (d & wmask(idx));
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start;
        m_sda = 1'b1; hold(Q);
        m_scl = 1'b1; hold(Q);
        m_sda = 1'b0; hold(Q);
        m_scl = 1'b0; hold(Q);
    endtask

    task automatic i2c_stop;
        m_sda = 1'b0; hold(Q);
        m_scl = 1'b1; hold(Q);
        m_sda = 1'b1; hold(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    hold(Q);
        m_scl = 1'b1; hold(2 * Q);
        m_scl = 1'b0; hold(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; hold(Q);
        m_scl = 1'b1; hold(Q);
        b = sda_line; hold(Q);
        m_scl = 1'b0; hold(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        get_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        send_bit(last);
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++) check(req, regs[8*i +: 8], exp_r[i]);
    endtask

    task automatic write_burst(input int n, input logic [7:0] base, input logic rnd, input string req);
        logic a;
        logic [7:0] d;
        i2c_start;
        send_byte(8'hD2, a);            check("R1 write address ack", {7'd0, a}, 8'd1);
        send_byte($urandom, a);         check("R2 command byte ack", {7'd0, a}, 8'd1);
        send_byte($urandom, a);         check("R2 count byte ack", {7'd0, a}, 8'd1);
        for (int k = 0; k < n; k++) begin
            d = rnd ? 8'($urandom) : base + 8'(k);
            send_byte(d, a);
            check(k >= NREG ? "R8 overrun ack" : "R4 data ack", {7'd0, a}, 8'd1);
            model_write(k, d);
        end
        i2c_stop;
        check_regs(req);
    endtask

    task automatic read_burst(input int n, input string req);
        logic a;
        logic [7:0] d;
        i2c_start;
        send_byte(8'hD3, a);            check("R1 read address ack", {7'd0, a}, 8'd1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, d);
            check(k >= NREG ? "R8 read past bank" : req, d, exp_read(k));
        end
        i2c_stop;
        check("R3 released after read", {7'd0, sda_oe}, 8'd0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic a;
        logic [7:0] d;
        void'($urandom(32'd4242));
        exp_r[0] = 8'h00; exp_r[1] = 8'h0F; exp_r[2] = 8'hFF; exp_r[3] = 8'h37;
        exp_r[4] = {4'hA, 4'h0}; exp_r[5] = 8'h03; exp_r[6] = 8'h57;
        hold(5);
        rst_n = 1'b1;
        hold(2);
        strap = 4'h5;   // R7: change after reset must be ignored
        hold(3);
        check("R5 data released after reset", {7'd0, sda_oe}, 8'd0);
        check_regs("R5 R7 reset defaults");

        // R3 R8: full read of defaults and past the bank
        read_burst(9, "R3 read defaults");

        // R1: wrong addresses get no ack, following bytes ignored
        i2c_start;
        send_byte(8'hA0, a); check("R1 foreign address nack", {7'd0, a}, 8'd0);
        send_byte(8'h00, a); check("R1 ignored byte nack", {7'd0, a}, 8'd0);
        send_byte(8'h11, a); check("R1 ignored byte nack", {7'd0, a}, 8'd0);
        i2c_stop;
        check_regs("R1 no change after foreign address");
        i2c_start;
        send_byte(8'hD1, a); check("R1 neighbour address nack", {7'd0, a}, 8'd0);
        i2c_stop;

        // R2 R6 R7 R8: directed full write including overrun
        write_burst(9, 8'hF0, 1'b0, "R2 R6 R7 R8 directed write");
        read_burst(8, "R3 read after directed write");

        // R9: write one byte, repeated start, read back
        i2c_start;
        send_byte(8'hD2, a); check("R9 address ack", {7'd0, a}, 8'd1);
        send_byte(8'h00, a); send_byte(8'h00, a);
        send_byte(8'h3C, a); check("R9 data ack", {7'd0, a}, 8'd1);
        model_write(0, 8'h3C);
        i2c_start;
        send_byte(8'hD3, a); check("R9 read address ack after restart", {7'd0, a}, 8'd1);
        recv_byte(1'b0, d);  check("R9 reg0 after restart", d, exp_r[0]);
        recv_byte(1'b1, d);  check("R9 reg1 after restart", d, exp_r[1]);
        i2c_stop;

        // Random write lengths and read-back
        for (int it = 0; it < 10; it++) begin
            write_burst(1 + int'($urandom % 9), 8'h00, 1'b1, "R2 R6 R7 random write");
            read_burst(1 + int'($urandom % 9), "R3 random read-back");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule